// File: doc/BRIEF.md
# Monitor Control Register with Access-Trap Routing

This block holds the global control word for a group of activity-monitor counters. It also decides what happens to every system-register access aimed at that word. The word is 64 bits wide, but only one bit in it can be stored. That bit chooses whether the counters stop while the processing element sits halted in debug state. The block turns it into a counting-enable output that the counters use directly.

Each access arrives as a one-cycle strobe that carries an instruction encoding, a read/write flag and write data. The block returns its verdict combinationally in the same cycle. There are three possible verdicts:

- **Success:** a read returns data, or a write takes effect.
- **Trap:** the trap goes to a named exception level and reports a fixed syndrome class.
- **Undefined:** the instruction is undefined.

Reads go through an ordered chain of trap checks, and the chain depends on the level making the access. Writes succeed only from the highest implemented level.

Top module: `amon_ctl_top`

## Requirements
- R1: After reset the halt-on-debug bit is 0, a permitted read returns all zeros, and `cnt_en` is 1 even while `dbg_halted` is 1.
- R2: Only a request with encoding op0=3, op1=3, CRn=13, CRm=2, op2=0 gets a response. Any other encoding raises none of `rsp_ok`, `trap_vld` or `undef`, and a write with that encoding leaves the register unchanged.
- R3: A write from the level equal to `top_lvl` succeeds and stores write-data bit 10 only. A later read returns that bit at position 10, and every other bit reads as 0.
- R4: A write from any level other than `top_lvl` raises `undef` and leaves the register unchanged.
- R5: A read from level 0 first applies the user-enable check. If level 1 uses 64-bit mode (`lvl1_aa32`=0) and `usr_en`=0, the read traps. The target is level 2 when level 2 is enabled, uses 64-bit mode and has `lvl2_tge`=1. Otherwise the target is level 1.
- R6: If the user-enable check passes at level 0, the level-2 monitor trap is checked next. It applies when level 2 is enabled, uses 64-bit mode and has `lvl2_tam`=1, and sends the read to level 2. The level-3 monitor trap is checked after that. It applies when level 3 exists, uses 64-bit mode and has `lvl3_tam`=1, and sends the read to level 3. If neither applies, the read succeeds.
- R7: A read from level 1 ignores the user-enable check. It applies the level-2 monitor trap and then the level-3 monitor trap, and succeeds if neither applies.
- R8: A read from level 2 applies only the level-3 monitor trap. A read from level 3 always succeeds.
- R9: Every matched request raises exactly one of `rsp_ok`, `trap_vld` or `undef`. Every trap drives `trap_ec` to 0x18.
- R10: When `trap_vld` or `undef` is high, `rsp_rdata` is zero.
- R11: `cnt_en` is 0 exactly when the stored halt bit is 1 and `dbg_halted` is 1.
- R12: The verdict and the read data appear in the same cycle as the request strobe. A permitted write becomes visible from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | One-cycle access strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| cur_lvl | input | 2 | Exception level making the access |
| top_lvl | input | 2 | Highest implemented level |
| lvl1_aa32 | input | 1 | Level 1 uses 32-bit mode |
| usr_en | input | 1 | User-level access enable |
| lvl2_on | input | 1 | Level 2 enabled |
| lvl2_aa32 | input | 1 | Level 2 uses 32-bit mode |
| lvl2_tge | input | 1 | Level 2 takes level-0 traps |
| lvl2_tam | input | 1 | Level-2 monitor trap control |
| lvl3_on | input | 1 | Level 3 implemented |
| lvl3_aa32 | input | 1 | Level 3 uses 32-bit mode |
| lvl3_tam | input | 1 | Level-3 monitor trap control |
| dbg_halted | input | 1 | Processing element halted in debug state |
| rsp_ok | output | 1 | Access succeeded |
| rsp_rdata | output | 64 | Read data |
| trap_vld | output | 1 | Access traps |
| trap_lvl | output | 2 | Trap target level |
| trap_ec | output | 6 | Syndrome exception class |
| undef | output | 1 | Undefined-instruction result |
| cnt_en | output | 1 | Counting enable for the counters |

## Verification
The read chain is exercised by driving one read per configuration of the level flags and trap bits. Each configuration is chosen so that a single check in the chain decides the outcome: the user-enable check with and without TGE, a level-2 trap that masks a pending level-3 trap, a level-3 trap that is reached only because level 2 is disabled or in 32-bit mode, and a clean pass. This separates a wrong order from a wrong target level. Writes are issued with all-ones data from the top level, from a lower level, and with a mismatched encoding. The following readback then separates stored bits from ignored bits and permitted writes from blocked ones. The counting gate is observed with `dbg_halted` at 1 and at 0 for both values of the stored bit.

// File: rtl/amon_ctl_pkg.sv
package amon_ctl_pkg;

  typedef enum logic [1:0] {LV0 = 2'd0, LV1 = 2'd1, LV2 = 2'd2, LV3 = 2'd3} lvl_e;

  // level configuration seen by the permission chain
  typedef struct packed {
    logic l1_aa32;
    logic usr_en;
    logic l2_on;
    logic l2_aa32;
    logic l2_tge;
    logic l2_tam;
    logic l3_on;
    logic l3_aa32;
    logic l3_tam;
  } acc_cfg_t;

  typedef struct packed {
    logic ok;
    logic trap;
    logic undef;
    lvl_e tgt;
  } verdict_t;

  function automatic verdict_t pass_v();
    verdict_t v;
    v = '0;
    v.ok = 1'b1;
    return v;
  endfunction

  function automatic verdict_t trap_v(lvl_e t);
    verdict_t v;
    v = '0;
    v.trap = 1'b1;
    v.tgt  = t;
    return v;
  endfunction

  function automatic logic l2_monitor_trap(acc_cfg_t c);
    return c.l2_on && !c.l2_aa32 && c.l2_tam;
  endfunction

  function automatic logic l3_monitor_trap(acc_cfg_t c);
    return c.l3_on && !c.l3_aa32 && c.l3_tam;
  endfunction

  // ordered read chain; first applicable check wins
  function automatic verdict_t read_verdict(lvl_e lv, acc_cfg_t c);
    verdict_t v;
    v = pass_v();
    case (lv)
      LV0: begin
        if (!c.l1_aa32 && !c.usr_en)
          v = trap_v((c.l2_on && !c.l2_aa32 && c.l2_tge) ? LV2 : LV1);
        else if (l2_monitor_trap(c)) v = trap_v(LV2);
        else if (l3_monitor_trap(c)) v = trap_v(LV3);
      end
      LV1: begin
        if (l2_monitor_trap(c))      v = trap_v(LV2);
        else if (l3_monitor_trap(c)) v = trap_v(LV3);
      end
      LV2: begin
        if (l3_monitor_trap(c)) v = trap_v(LV3);
      end
      default: v = pass_v();
    endcase
    return v;
  endfunction

  function automatic verdict_t write_verdict(lvl_e lv, lvl_e top);
    verdict_t v;
    v = '0;
    if (lv == top) v.ok = 1'b1;
    else           v.undef = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/amon_ctl_decode.sv
module amon_ctl_decode #(
  parameter logic [1:0] ENC_OP0 = 2'd3,
  parameter logic [2:0] ENC_OP1 = 3'd3,
  parameter logic [3:0] ENC_CRN = 4'd13,
  parameter logic [3:0] ENC_CRM = 4'd2,
  parameter logic [2:0] ENC_OP2 = 3'd0
) (
  input  logic       req_vld,
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit
);
  localparam logic [15:0] ENC_KEY = {ENC_OP0, ENC_OP1, ENC_CRN, ENC_CRM, ENC_OP2};

  assign hit = req_vld && ({op0, op1, crn, crm, op2} == ENC_KEY);
endmodule

// File: rtl/amon_ctl_perm.sv
module amon_ctl_perm
  import amon_ctl_pkg::*;
(
  input  logic     hit,
  input  logic     req_wr,
  input  lvl_e     cur_lvl,
  input  lvl_e     top_lvl,
  input  acc_cfg_t cfg,
  output verdict_t verdict
);
  always_comb begin
    if (!hit)        verdict = '0;
    else if (req_wr) verdict = write_verdict(cur_lvl, top_lvl);
    else             verdict = read_verdict(cur_lvl, cfg);
  end
endmodule

// File: rtl/amon_ctl_store.sv
module amon_ctl_store #(
  parameter int DATA_W   = 64,
  parameter int HALT_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bit,
  input  logic              rd_en,
  input  logic              dbg_halted,
  output logic              halt_q,
  output logic [DATA_W-1:0] rdata,
  output logic              cnt_en
);
  logic [DATA_W-1:0] image;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     halt_q <= 1'b0;
    else if (wr_en) halt_q <= wr_bit;
  end

  // every position except the halt bit reads as zero
  for (genvar i = 0; i < DATA_W; i++) begin : g_img
    if (i == HALT_BIT) begin : g_live
      assign image[i] = halt_q;
    end else begin : g_zero
      assign image[i] = 1'b0;
    end
  end

  assign rdata  = rd_en ? image : '0;
  assign cnt_en = !(halt_q && dbg_halted);
endmodule

// File: rtl/amon_ctl_top.sv
module amon_ctl_top
  import amon_ctl_pkg::*;
#(
  parameter int          DATA_W   = 64,
  parameter int          HALT_BIT = 10,
  parameter int          EC_W     = 6,
  parameter logic [EC_W-1:0] EC_VAL = 6'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [1:0]        req_op0,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cur_lvl,
  input  logic [1:0]        top_lvl,
  input  logic              lvl1_aa32,
  input  logic              usr_en,
  input  logic              lvl2_on,
  input  logic              lvl2_aa32,
  input  logic              lvl2_tge,
  input  logic              lvl2_tam,
  input  logic              lvl3_on,
  input  logic              lvl3_aa32,
  input  logic              lvl3_tam,
  input  logic              dbg_halted,
  output logic              rsp_ok,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              trap_vld,
  output logic [1:0]        trap_lvl,
  output logic [EC_W-1:0]   trap_ec,
  output logic              undef,
  output logic              cnt_en
);
  // named internal events for the checker
  logic     hit;
  logic     wr_ok;
  logic     rd_ok;
  logic     halt_bit;
  acc_cfg_t cfg;
  verdict_t verdict;
  logic     unused_wdata;

  assign cfg = '{l1_aa32: lvl1_aa32, usr_en: usr_en,
                 l2_on: lvl2_on, l2_aa32: lvl2_aa32, l2_tge: lvl2_tge, l2_tam: lvl2_tam,
                 l3_on: lvl3_on, l3_aa32: lvl3_aa32, l3_tam: lvl3_tam};

  assign unused_wdata = ^{req_wdata[DATA_W-1:HALT_BIT+1], req_wdata[HALT_BIT-1:0]};

  amon_ctl_decode dec_i (
    .req_vld (req_vld),
    .op0     (req_op0),
    .op1     (req_op1),
    .crn     (req_crn),
    .crm     (req_crm),
    .op2     (req_op2),
    .hit     (hit)
  );

  amon_ctl_perm perm_i (
    .hit     (hit),
    .req_wr  (req_wr),
    .cur_lvl (lvl_e'(cur_lvl)),
    .top_lvl (lvl_e'(top_lvl)),
    .cfg     (cfg),
    .verdict (verdict)
  );

  assign wr_ok = verdict.ok && req_wr;
  assign rd_ok = verdict.ok && !req_wr;

  amon_ctl_store #(.DATA_W(DATA_W), .HALT_BIT(HALT_BIT)) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_ok),
    .wr_bit     (req_wdata[HALT_BIT]),
    .rd_en      (rd_ok),
    .dbg_halted (dbg_halted),
    .halt_q     (halt_bit),
    .rdata      (rsp_rdata),
    .cnt_en     (cnt_en)
  );

  assign rsp_ok   = verdict.ok;
  assign trap_vld = verdict.trap;
  assign undef    = verdict.undef;
  assign trap_lvl = verdict.trap ? verdict.tgt : 2'd0;
  assign trap_ec  = verdict.trap ? EC_VAL : '0;
endmodule

// File: rtl/amon_ctl_chk.sv
module amon_ctl_chk #(
  parameter int DATA_W   = 64,
  parameter int HALT_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic              req_wr,
  input logic              wbit,
  input logic [1:0]        cur_lvl,
  input logic              hit,
  input logic              halt_bit,
  input logic              rsp_ok,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              trap_vld,
  input logic [1:0]        trap_lvl,
  input logic [5:0]        trap_ec,
  input logic              undef,
  input logic              dbg_halted,
  input logic              cnt_en
);
  p_no_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !hit) |-> (!rsp_ok && !trap_vld && !undef));

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok && req_wr) |=> (halt_bit == $past(wbit)));

  p_undef_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    undef |=> $stable(halt_bit));

  p_el1_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld && cur_lvl == 2'd1) |-> (trap_lvl >= 2'd2));

  p_el3_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !req_wr && cur_lvl == 2'd3) |-> rsp_ok);

  p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($countones({rsp_ok, trap_vld, undef}) == 1));

  p_syndrome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld |-> (trap_ec == 6'h18));

  p_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld || undef) |-> (rsp_rdata == '0));

  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_halted |-> cnt_en);

  p_rdata_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rsp_rdata) <= 1);
endmodule

bind amon_ctl_top amon_ctl_chk #(.DATA_W(DATA_W), .HALT_BIT(HALT_BIT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_vld    (req_vld),
  .req_wr     (req_wr),
  .wbit       (req_wdata[HALT_BIT]),
  .cur_lvl    (cur_lvl),
  .hit        (hit),
  .halt_bit   (halt_bit),
  .rsp_ok     (rsp_ok),
  .rsp_rdata  (rsp_rdata),
  .trap_vld   (trap_vld),
  .trap_lvl   (trap_lvl),
  .trap_ec    (trap_ec),
  .undef      (undef),
  .dbg_halted (dbg_halted),
  .cnt_en     (cnt_en)
);

// File: tb/amon_ctl_top_tb_top.sv
module amon_ctl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [1:0]  req_op0 = '0;
  logic [2:0]  req_op1 = '0;
  logic [3:0]  req_crn = '0;
  logic [3:0]  req_crm = '0;
  logic [2:0]  req_op2 = '0;
  logic        req_wr = 1'b0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  cur_lvl = '0;
  logic [1:0]  top_lvl = 2'd3;
  logic        lvl1_aa32 = 1'b0, usr_en = 1'b1;
  logic        lvl2_on = 1'b1, lvl2_aa32 = 1'b0, lvl2_tge = 1'b0, lvl2_tam = 1'b0;
  logic        lvl3_on = 1'b1, lvl3_aa32 = 1'b0, lvl3_tam = 1'b0;
  logic        dbg_halted = 1'b0;
  logic        rsp_ok, trap_vld, undef, cnt_en;
  logic [63:0] rsp_rdata;
  logic [1:0]  trap_lvl;
  logic [5:0]  trap_ec;

  always #5 clk = ~clk;

  amon_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
    .req_wr(req_wr), .req_wdata(req_wdata), .cur_lvl(cur_lvl), .top_lvl(top_lvl),
    .lvl1_aa32(lvl1_aa32), .usr_en(usr_en),
    .lvl2_on(lvl2_on), .lvl2_aa32(lvl2_aa32), .lvl2_tge(lvl2_tge), .lvl2_tam(lvl2_tam),
    .lvl3_on(lvl3_on), .lvl3_aa32(lvl3_aa32), .lvl3_tam(lvl3_tam),
    .dbg_halted(dbg_halted),
    .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata), .trap_vld(trap_vld), .trap_lvl(trap_lvl),
    .trap_ec(trap_ec), .undef(undef), .cnt_en(cnt_en)
  );

  typedef struct {
    string       tag;
    bit          ok;
    bit          trap;
    bit          udf;
    logic [1:0]  lvl;
    logic [63:0] rdata;
    bit          cnt;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   mdl_halt = 1'b0;
  bit   done = 1'b0;

  task automatic check(input string tag, input string fld, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, got, exp);
    end
  endtask

  // driver: applies one request and queues its expected verdict
  task automatic issue(input string tag, input bit wr, input logic [63:0] wd,
                       input logic [1:0] lv, input bit enc_ok, input bit dbg);
    exp_t e;
    int   tgt;
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_wdata = wd; cur_lvl = lv; dbg_halted = dbg;
    req_op0 = 2'd3; req_op1 = 3'd3; req_crn = 4'd13; req_op2 = 3'd0;
    req_crm = enc_ok ? 4'd2 : 4'd3;
    e.tag = tag; e.ok = 0; e.trap = 0; e.udf = 0; e.lvl = 0; e.rdata = '0;
    e.cnt = !(mdl_halt && dbg);
    if (enc_ok && wr) begin
      if (lv == top_lvl) e.ok = 1; else e.udf = 1;
    end else if (enc_ok) begin
      tgt = -1;
      if (lv == 0 && !lvl1_aa32 && !usr_en)
        tgt = (lvl2_on && !lvl2_aa32 && lvl2_tge) ? 2 : 1;
      if (tgt < 0 && lv <= 1 && lvl2_on && !lvl2_aa32 && lvl2_tam) tgt = 2;
      if (tgt < 0 && lv <= 2 && lvl3_on && !lvl3_aa32 && lvl3_tam) tgt = 3;
      if (tgt < 0) begin
        e.ok = 1;
        e.rdata = 64'(mdl_halt) << 10;
      end else begin
        e.trap = 1;
        e.lvl = 2'(tgt);
      end
    end
    q.push_back(e);
    if (enc_ok && wr && lv == top_lvl) mdl_halt = wd[10];
    #2;
  endtask

  // monitor: same-cycle verdict (R12), compared one slot after the drive
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "rsp_ok", 64'(rsp_ok), 64'(e.ok));
        check(e.tag, "trap_vld", 64'(trap_vld), 64'(e.trap));
        check(e.tag, "undef", 64'(undef), 64'(e.udf));
        check(e.tag, "rsp_rdata R10", rsp_rdata, e.rdata);
        check(e.tag, "cnt_en R11", 64'(cnt_en), 64'(e.cnt));
        if (e.trap) begin
          check(e.tag, "trap_lvl", 64'(trap_lvl), 64'(e.lvl));
          check(e.tag, "trap_ec R9", 64'(trap_ec), 64'h18);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    issue("R1 reset read", 0, '0, 2'd3, 1, 0);
    issue("R1 reset gate open while halted", 0, '0, 2'd3, 1, 1);
    issue("R3 top-level write all ones", 1, '1, 2'd3, 1, 0);
    issue("R3 readback shows only bit 10", 0, '0, 2'd3, 1, 0);
    issue("R11 halted with bit set", 0, '0, 2'd3, 1, 1);
    issue("R4 write from level 1", 1, '0, 2'd1, 1, 0);
    issue("R4 value unchanged", 0, '0, 2'd3, 1, 0);
    issue("R2 mismatched encoding write", 1, '0, 2'd3, 0, 0);
    issue("R2 value unchanged", 0, '0, 2'd3, 1, 0);
    // R5 user-enable check
    usr_en = 0;
    issue("R5 el0 trap to level 1", 0, '0, 2'd0, 1, 0);
    lvl2_tge = 1;
    issue("R5 el0 trap to level 2 via tge", 0, '0, 2'd0, 1, 0);
    lvl2_aa32 = 1;
    issue("R5 tge ignored when level 2 is 32-bit", 0, '0, 2'd0, 1, 0);
    lvl2_aa32 = 0; lvl1_aa32 = 1;
    issue("R5 check skipped when level 1 is 32-bit", 0, '0, 2'd0, 1, 0);
    lvl1_aa32 = 0; usr_en = 1; lvl2_tge = 0;
    // R6 remaining level-0 chain
    lvl2_tam = 1; lvl3_tam = 1;
    issue("R6 level 2 trap wins over level 3", 0, '0, 2'd0, 1, 1);
    lvl2_on = 0;
    issue("R6 level 3 trap when level 2 off", 0, '0, 2'd0, 1, 0);
    lvl3_aa32 = 1;
    issue("R6 pass when level 3 is 32-bit", 0, '0, 2'd0, 1, 0);
    lvl3_aa32 = 0; lvl2_on = 1;
    // R7 level 1 chain
    issue("R7 el1 trap to level 2", 0, '0, 2'd1, 1, 0);
    lvl2_tam = 0;
    issue("R7 el1 trap to level 3", 0, '0, 2'd1, 1, 0);
    lvl3_tam = 0; usr_en = 0;
    issue("R7 el1 pass ignores user enable", 0, '0, 2'd1, 1, 0);
    // R8 level 2 / level 3
    lvl2_tam = 1;
    issue("R8 el2 ignores level 2 trap", 0, '0, 2'd2, 1, 0);
    lvl3_tam = 1;
    issue("R8 el2 trap to level 3", 0, '0, 2'd2, 1, 0);
    issue("R8 el3 always reads", 0, '0, 2'd3, 1, 0);
    lvl3_on = 0;
    issue("R8 el2 pass when level 3 absent", 0, '0, 2'd2, 1, 0);
    lvl3_on = 1; lvl2_tam = 0; lvl3_tam = 0; usr_en = 1;
    // R3 with a lower highest level
    top_lvl = 2'd2;
    issue("R3 write from level 2 as top", 1, '0, 2'd2, 1, 0);
    issue("R4 write from level 3 when top is 2", 1, '1, 2'd3, 1, 0);
    issue("R11 gate open with bit clear", 0, '0, 2'd2, 1, 1);
    @(negedge clk);
    req_vld = 1'b0;
    wait (q.size() == 0);
    #20;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule